// File: doc/BRIEF.md
# Alternating-Clock Byte Receiver

This block turns activity on a two-wire serial bus into bytes. Neither wire is a dedicated clock. Each wire takes a turn as the clock while the other carries the data. A falling edge on wire A samples wire B. A falling edge on wire B samples wire A. The edges must strictly alternate, starting with A. Four such pairs give one 8-bit byte, most significant bit first.

A controller pulses `start_i` once it has recognised the beginning of a frame. The receiver then collects bytes and presents each one on `byte_o` with a one-cycle `byte_vld_o` strobe. It keeps doing this until one of two things happens:
- it sees the end-of-frame pattern and raises a one-cycle `end_o`;
- it sees an edge that breaks the alternation rule and raises a one-cycle `err_o`.

In both cases it returns to idle and waits for the next start pulse. The wires are synchronised into the system clock domain. That clock is assumed to run at least four times faster than the bus edge rate.

Top module: `altclk_rx`

## Requirements
- R1: In a byte, a falling edge of wire A while the A-edge and B-edge counts are equal shifts the level of wire B into the byte as the next bit. The first bit taken becomes bit 7 of `byte_o`.
- R2: A falling edge of wire B while the A-edge count exceeds the B-edge count by one shifts the level of wire A into the byte as the next bit.
- R3: After the fourth B-edge of a byte, `byte_o` is not presented until wire A is high. It then carries the eight bits with `byte_vld_o` high for exactly one cycle, and the next byte begins with cleared counts.
- R4: Before the first bit of a byte, one falling edge of wire B taken while wire A is high is ignored as a setup edge. A second such edge in the same byte is a framing error.
- R5: The end pattern is recognised as follows. After exactly one A-edge that sampled wire B as 0, with no B-edge yet, a second A-edge arrives while B is still 0. After that, both wires go high. The block then raises `end_o` for one cycle and returns to idle (`busy_o` low).
- R6: A falling edge that breaks the A-then-B alternation raises `err_o` for one cycle and returns to idle, with no byte strobe for the broken byte.
- R7: While the end pattern is pending (after the second A-edge and before both wires are high), any falling edge on either wire is a framing error rather than an end.
- R8: In idle, wire activity produces no byte, end or error. Only `start_i` makes the block busy, and a `start_i` pulse while busy has no effect on the bytes received.
- R9: After reset, `busy_o`, `byte_vld_o`, `end_o` and `err_o` are low.
- R10: Falling edges on both wires seen in the same system-clock cycle are a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins reception |
| line_a_i | input | 1 | Bus wire A (asynchronous) |
| line_b_i | input | 1 | Bus wire B (asynchronous) |
| byte_o | output | BYTE_BITS | Last received byte |
| byte_vld_o | output | 1 | One-cycle strobe: `byte_o` is new |
| end_o | output | 1 | One-cycle strobe: end pattern seen |
| err_o | output | 1 | One-cycle strobe: framing error |
| busy_o | output | 1 | Receiver is inside a frame |

## Verification
The assertions take four things for granted about the inputs:
- each wire level is held for several system clocks between changes;
- a fall is therefore visible for exactly one cycle after synchronisation;
- the edge counts stay within one step of each other;
- a strobe always follows the wire condition that triggers it.

The stimulus keeps within these limits by changing the wires only on the falling system-clock edge. Every wire step is held for six cycles, which is well above the synchroniser depth plus the edge register. Wire changes between sampling edges are made only as rises, except where a test deliberately injects a stray fall.

// File: rtl/altclk_pkg.sv
package altclk_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_BITS = 2'd1,
        MODE_HOLD = 2'd2,
        MODE_ENDW = 2'd3
    } rx_mode_e;

endpackage

// File: rtl/altclk_line_edge.sv
module altclk_line_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q, sync_d;
    logic              prev_q, prev_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign lvl_o  = sync_q[STAGES-1];
    assign fall_o = prev_q & ~sync_q[STAGES-1];

    // a fall on a slow wire lasts exactly one cycle (feeds R1, R2)
    p_fall_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/altclk_rx_core.sv
module altclk_rx_core
    import altclk_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 a_lvl,
    input  logic                 b_lvl,
    input  logic                 a_fall,
    input  logic                 b_fall,
    output logic [BYTE_BITS-1:0] byte_o,
    output logic                 byte_vld_o,
    output logic                 end_o,
    output logic                 err_o,
    output logic                 busy_o
);

    localparam int PAIRS = BYTE_BITS / 2;
    localparam int CW    = $clog2(PAIRS + 1);
    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] LAST_CNT = CW'(PAIRS - 1);

    typedef struct packed {
        rx_mode_e             mode;
        logic [CW-1:0]        cnt_a;
        logic [CW-1:0]        cnt_b;
        logic [BYTE_BITS-1:0] shreg;
        logic                 setup_used;
        logic [BYTE_BITS-1:0] dout;
        logic                 vld;
        logic                 endp;
        logic                 err;
    } core_t;

    core_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.endp = 1'b0;
        st_d.err  = 1'b0;
        unique case (st_q.mode)
            MODE_IDLE: begin
                if (start_i) begin
                    st_d.mode       = MODE_BITS;
                    st_d.cnt_a      = '0;
                    st_d.cnt_b      = '0;
                    st_d.shreg      = '0;
                    st_d.setup_used = 1'b0;
                end
            end
            MODE_BITS: begin
                if (a_fall && b_fall) begin
                    st_d.err  = 1'b1;
                    st_d.mode = MODE_IDLE;
                end else if (a_fall) begin
                    if (st_q.cnt_a == st_q.cnt_b) begin
                        st_d.shreg = {st_q.shreg[BYTE_BITS-2:0], b_lvl};
                        st_d.cnt_a = st_q.cnt_a + ONE;
                    end else if (st_q.cnt_a == ONE && st_q.cnt_b == '0 &&
                                 st_q.shreg == '0 && !b_lvl) begin
                        st_d.mode = MODE_ENDW;
                    end else begin
                        st_d.err  = 1'b1;
                        st_d.mode = MODE_IDLE;
                    end
                end else if (b_fall) begin
                    if (st_q.cnt_a == st_q.cnt_b + ONE) begin
                        st_d.shreg = {st_q.shreg[BYTE_BITS-2:0], a_lvl};
                        st_d.cnt_b = st_q.cnt_b + ONE;
                        if (st_q.cnt_b == LAST_CNT) begin
                            st_d.mode = MODE_HOLD;
                        end
                    end else if (st_q.cnt_a == '0 && st_q.cnt_b == '0 &&
                                 a_lvl && !st_q.setup_used) begin
                        st_d.setup_used = 1'b1;
                    end else begin
                        st_d.err  = 1'b1;
                        st_d.mode = MODE_IDLE;
                    end
                end
            end
            MODE_HOLD: begin
                if (a_fall || b_fall) begin
                    st_d.err  = 1'b1;
                    st_d.mode = MODE_IDLE;
                end else if (a_lvl) begin
                    st_d.dout       = st_q.shreg;
                    st_d.vld        = 1'b1;
                    st_d.mode       = MODE_BITS;
                    st_d.cnt_a      = '0;
                    st_d.cnt_b      = '0;
                    st_d.shreg      = '0;
                    st_d.setup_used = 1'b0;
                end
            end
            MODE_ENDW: begin
                if (a_fall || b_fall) begin
                    st_d.err  = 1'b1;
                    st_d.mode = MODE_IDLE;
                end else if (a_lvl && b_lvl) begin
                    st_d.endp = 1'b1;
                    st_d.mode = MODE_IDLE;
                end
            end
            default: st_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_o     = st_q.dout;
    assign byte_vld_o = st_q.vld;
    assign end_o      = st_q.endp;
    assign err_o      = st_q.err;
    assign busy_o     = (st_q.mode != MODE_IDLE);

    // edge counts never drift more than one step apart (R1, R2)
    p_count_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt_b <= st_q.cnt_a) && (st_q.cnt_a <= st_q.cnt_b + ONE));

    // a byte strobe only follows wire A seen high (R3)
    p_vld_after_a_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> $past(a_lvl));

    // end strobe leaves the block idle (R5)
    p_end_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |-> !busy_o);

    // end strobe only once both wires were high (R5)
    p_end_needs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |-> ($past(a_lvl) && $past(b_lvl)));

    // error strobe leaves the block idle (R6)
    p_err_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);

    // an error follows a wire fall (R6, R7, R10)
    p_err_needs_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(a_fall) || $past(b_fall)));

    // idle without start stays quiet (R8)
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!byte_vld_o && !end_o && !err_o && !busy_o));

    // at most one strobe per cycle (R3, R5, R6)
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_vld_o, end_o, err_o}));

endmodule

// File: rtl/altclk_rx.sv
module altclk_rx #(
    parameter int BYTE_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 line_a_i,
    input  logic                 line_b_i,
    output logic [BYTE_BITS-1:0] byte_o,
    output logic                 byte_vld_o,
    output logic                 end_o,
    output logic                 err_o,
    output logic                 busy_o
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] wire_in;
    logic [NLINES-1:0] wire_lvl;
    logic [NLINES-1:0] wire_fall;

    assign wire_in = {line_b_i, line_a_i};

    for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
        altclk_line_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (wire_in[gi]),
            .lvl_o  (wire_lvl[gi]),
            .fall_o (wire_fall[gi])
        );
    end

    altclk_rx_core #(.BYTE_BITS(BYTE_BITS)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .a_lvl      (wire_lvl[0]),
        .b_lvl      (wire_lvl[1]),
        .a_fall     (wire_fall[0]),
        .b_fall     (wire_fall[1]),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld_o),
        .end_o      (end_o),
        .err_o      (err_o),
        .busy_o     (busy_o)
    );

    // reset leaves every strobe low (R9)
    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!byte_vld_o && !end_o && !err_o));

endmodule

// File: tb/tb_altclk_rx.sv
module tb_altclk_rx;

    localparam int GAP  = 6;
    localparam int NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'h5A, 8'hA5, 8'h00, 8'hFF,
                                          8'h3C, 8'h81, 8'h01, 8'h80};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       la = 1'b1;
    logic       lb = 1'b1;
    logic [7:0] byte_o;
    logic       byte_vld_o, end_o, err_o, busy_o;

    int n_chk = 0;
    int n_bad = 0;
    int cap_n = 0;
    int end_n = 0;
    int err_n = 0;
    logic [7:0] cap [64];

    always #5 clk = ~clk;

    altclk_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .line_a_i   (la),
        .line_b_i   (lb),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld_o),
        .end_o      (end_o),
        .err_o      (err_o),
        .busy_o     (busy_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld_o) begin
                if (cap_n < 64) cap[cap_n] = byte_o;
                cap_n++;
            end
            if (end_o) end_n++;
            if (err_o) err_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic b);
        @(negedge clk);
        la = a;
        lb = b;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit hold);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, d[7-2*k]);
            step(1'b0, d[7-2*k]);
            step(d[6-2*k], 1'b1);
            step(d[6-2*k], 1'b0);
        end
        if (!hold) step(1'b1, 1'b0);
    endtask

    task automatic send_end();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int base, e0, r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 reset state
        chk("R9 busy", busy_o, 0);
        chk("R9 strobes", {byte_vld_o, end_o, err_o}, 0);

        // R8 idle ignores wires
        step(1, 0); step(0, 0); step(0, 1); step(0, 0); step(1, 0);
        step(0, 0); step(1, 0); step(1, 1);
        chk("R8 idle bytes", cap_n, 0);
        chk("R8 idle errs", err_n + end_n, 0);
        chk("R8 idle busy", busy_o, 0);

        // vector walk: R1/R2 assembly, R4 setup edge on first byte, R8 start ignored
        pulse_start();
        chk("R8 busy after start", busy_o, 1);
        base = cap_n;
        for (int i = 0; i < NVEC; i++) begin
            send_byte(VEC[i], 1'b0);
            if (i == 2) pulse_start();
        end
        chk("R3 byte count", cap_n - base, NVEC);
        for (int i = 0; i < NVEC; i++) begin
            chk($sformatf("R1/R2 byte %0d", i), cap[base+i], VEC[i]);
        end
        chk("R6 no error in frame", err_n, 0);
        send_end();
        chk("R5 end seen", end_n, 1);
        chk("R5 idle after end", busy_o, 0);

        // R3 byte held until A high
        pulse_start();
        base = cap_n;
        send_byte(8'hFE, 1'b1);
        repeat (20) @(negedge clk);
        chk("R3 no byte while A low", cap_n - base, 0);
        step(1, 0);
        chk("R3 byte after A high", cap_n - base, 1);
        chk("R3 byte value", cap[base], 8'hFE);
        send_end();
        chk("R5 second end", end_n, 2);

        // R4 second setup edge is an error
        r0 = err_n; base = cap_n;
        pulse_start();
        step(1, 0); step(1, 1); step(1, 0);
        chk("R4 second setup error", err_n - r0, 1);
        chk("R4 idle", busy_o, 0);
        chk("R4 no byte", cap_n - base, 0);
        step(1, 1);

        // R6 repeated A edge after a 1 bit
        r0 = err_n; e0 = end_n;
        pulse_start();
        step(0, 1); step(1, 1); step(0, 1);
        chk("R6 alternation error", err_n - r0, 1);
        chk("R6 not an end", end_n - e0, 0);
        chk("R6 idle", busy_o, 0);
        step(1, 1);

        // R7 B fall while end pending
        r0 = err_n; e0 = end_n;
        pulse_start();
        step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        step(0, 1); step(0, 0);
        chk("R7 pending end error", err_n - r0, 1);
        step(1, 1);
        chk("R7 no end", end_n - e0, 0);

        // R10 simultaneous falls
        r0 = err_n;
        pulse_start();
        step(0, 0);
        chk("R10 both fall error", err_n - r0, 1);
        chk("R10 idle", busy_o, 0);
        step(1, 1);

        finish_run();
    end

endmodule